// File: doc/BRIEF.md
# Pad Function Selector with Override Control

This block sits between one device pad and the on-chip sources that might want it. A control word chooses one of nine function slots. Eight slots belong to hardware peripherals, each of which supplies an output value and an output enable. The remaining slot, index 5, belongs to the bank's software GPIO register bits. The selected source's output value, its output enable and the value read back from the pad each pass through a two-bit override. The override can pass the signal, invert it, hold it at 0 or hold it at 1. Only the selected function sees the pad input; every other destination reads 0. Any code of 9 or above, including the all-ones code 0x1f, leaves the pin with no owner, and the pin then never drives.

A second word holds the static pad settings: slew, Schmitt trigger, pull, drive strength, input enable and output disable. These settings are exported as plain outputs so the pad cell can use them. Output disable and input enable also act on the logic paths. Output disable keeps the pad from driving, and a cleared input enable makes the received value read as 0 before the input override is applied. Both words are written and read over a small synchronous register bus. The pad paths are combinational from the stored words and the live inputs.

Top module: `pinmux_pin`

## Requirements
- R1: After reset, the control word reads 0x0000801F (function code 0x1f, output-enable override 2), the pad word reads 0x00000040 (input enable only), pad_oe is 0, and every input destination reads 0.
- R2: For a function code f in 0..8 other than 5, with all overrides at 0, pad_out and pad_oe equal the output pair of peripheral index f (for f below 5) or f-1 (for f above 5).
- R3: Function code 5 takes pad_out and pad_oe from sw_out and sw_oe and ignores every peripheral output pair, and the pad input is delivered on sw_in.
- R4: A function code of 9 or more, including 0x1f, keeps pad_oe at 0 whatever the output-enable override holds, and holds sw_in and every periph_in bit at 0.
- R5: The output override in control bits 13:12 gives pad_out as the selected value (0), its inverse (1), 0 (2) or 1 (3).
- R6: The output-enable override in control bits 15:14 gives the enable as the selected enable (0), its inverse (1), 0 (2) or 1 (3).
- R7: The input override in control bits 17:16 (0 pass, 1 invert, 2 force 0, 3 force 1) is applied to the pad input, and the result reaches only the destination of the selected function. All other destinations read 0.
- R8: While pad bit 6 (input enable) is 0, the pad input is taken as 0 before the input override is applied.
- R9: While pad bit 7 (output disable) is 1, pad_oe is 0 regardless of the function code and the overrides.
- R10: Pad bits are exported as follows: bit 0 is pad_slew_fast, bit 1 is pad_schmitt_en, bits 3:2 are pad_pull (0 off, 1 down, 2 up), bits 5:4 are pad_drive (codes 0..3 for 2, 4, 8, 12 mA), bit 6 is pad_in_en and bit 7 is pad_out_dis.
- R11: A write with reg_we high at a rising clock edge stores reg_wdata into the word addressed by reg_addr (0 is the control word, 1 is the pad word). The write is visible from that edge on. Control bits other than 17:12 and 4:0, and pad bits above 7, are not stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 control, 1 pad |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| periph_out | input | 8 | Output values of the hardware peripherals |
| periph_oe | input | 8 | Output enables of the hardware peripherals |
| periph_in | output | 8 | Pad input delivered to each hardware peripheral |
| sw_out | input | 1 | Software GPIO output value |
| sw_oe | input | 1 | Software GPIO output enable |
| sw_in | output | 1 | Pad input delivered to software GPIO |
| pad_in | input | 1 | Raw value received from the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad drive enable |
| pad_slew_fast | output | 1 | Fast slew select |
| pad_schmitt_en | output | 1 | Schmitt trigger enable |
| pad_pull | output | 2 | Pull select |
| pad_drive | output | 2 | Drive strength code |
| pad_in_en | output | 1 | Pad input buffer enable |
| pad_out_dis | output | 1 | Pad output disable |

## Verification
Every hardware function code is selected in turn. For each one, the selected peripheral's output pair is driven opposite to all the other peripherals' pairs, across all four value and enable combinations. This shows that the right source is chosen and that the index skips the software slot correctly. With code 5, the peripherals are driven against sw_out and sw_oe, which shows the software pair wins. Each override is swept over all four codes with both input values, so pass, invert and the two forced levels can each be told apart. The unowned codes 9, 15 and 31 are tried with the enable forced high, and the input-enable and output-disable bits are tried against settings that would otherwise drive or deliver a 1.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int REG_W     = 32;
    localparam int FSEL_W    = 5;
    localparam int PAD_W     = 8;
    localparam int OUT_LSB   = 12;
    localparam int OE_LSB    = 14;
    localparam int IN_LSB    = 16;

    localparam logic [FSEL_W-1:0] FSEL_UNOWNED = 5'h1f;

    typedef enum logic [1:0] {
        OVR_PASS = 2'd0,
        OVR_INV  = 2'd1,
        OVR_LOW  = 2'd2,
        OVR_HIGH = 2'd3
    } ovr_t;

    typedef struct packed {
        ovr_t              in_ovr;
        ovr_t              oe_ovr;
        ovr_t              out_ovr;
        logic [FSEL_W-1:0] fsel;
    } pin_ctrl_t;

    // packed MSB first: bit 7 down to bit 0 of the pad word
    typedef struct packed {
        logic       out_dis;
        logic       in_en;
        logic [1:0] drive;
        logic [1:0] pull;
        logic       schmitt;
        logic       slew_fast;
    } pad_cfg_t;

    localparam pin_ctrl_t CTRL_RESET = '{
        in_ovr:  OVR_PASS,
        oe_ovr:  OVR_LOW,
        out_ovr: OVR_PASS,
        fsel:    FSEL_UNOWNED
    };

    localparam pad_cfg_t PAD_RESET = '{
        out_dis:   1'b0,
        in_en:     1'b1,
        drive:     2'd0,
        pull:      2'd0,
        schmitt:   1'b0,
        slew_fast: 1'b0
    };

    function automatic logic ovr_apply(input ovr_t mode, input logic v);
        logic r;
        case (mode)
            OVR_PASS: r = v;
            OVR_INV:  r = ~v;
            OVR_LOW:  r = 1'b0;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input pin_ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[FSEL_W-1:0]         = c.fsel;
        w[OUT_LSB+1:OUT_LSB]  = c.out_ovr;
        w[OE_LSB+1:OE_LSB]    = c.oe_ovr;
        w[IN_LSB+1:IN_LSB]    = c.in_ovr;
        return w;
    endfunction

endpackage

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
    import pinmux_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       rdata,
    output pin_ctrl_t              ctrl_q,
    output pad_cfg_t               pad_q
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
    localparam logic [ADDR_W-1:0] PAD_ADDR  = ADDR_W'(1);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[REG_W-1:IN_LSB+2], wdata[OUT_LSB-1:PAD_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            pad_q  <= PAD_RESET;
        end else if (we) begin
            if (addr == CTRL_ADDR) begin
                ctrl_q.fsel    <= wdata[FSEL_W-1:0];
                ctrl_q.out_ovr <= ovr_t'(wdata[OUT_LSB+1:OUT_LSB]);
                ctrl_q.oe_ovr  <= ovr_t'(wdata[OE_LSB+1:OE_LSB]);
                ctrl_q.in_ovr  <= ovr_t'(wdata[IN_LSB+1:IN_LSB]);
            end else if (addr == PAD_ADDR) begin
                pad_q <= pad_cfg_t'(wdata[PAD_W-1:0]);
            end
        end
    end

    always_comb begin
        if (addr == CTRL_ADDR)
            rdata = ctrl_to_word(ctrl_q);
        else if (addr == PAD_ADDR)
            rdata = {{(REG_W-PAD_W){1'b0}}, pad_q};
        else
            rdata = '0;
    end

    // R11: a control write lands in the stored fields at the next edge
    a_r11_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == CTRL_ADDR) |=>
            (ctrl_q.fsel == $past(wdata[FSEL_W-1:0]) &&
             ctrl_q.out_ovr == $past(wdata[OUT_LSB+1:OUT_LSB]) &&
             ctrl_q.in_ovr == $past(wdata[IN_LSB+1:IN_LSB])));

    // R11: a pad write leaves the control word untouched
    a_r11_pad_write_isolated: assert property (@(posedge clk) disable iff (rst)
        (we && addr == PAD_ADDR) |=> $stable(ctrl_q));

endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux
    import pinmux_pkg::*;
#(
    parameter int NUM_FUNCS = 9,
    parameter int GPIO_FUNC = 5
) (
    input  logic [FSEL_W-1:0]      fsel,
    input  logic [NUM_FUNCS-2:0]   periph_out,
    input  logic [NUM_FUNCS-2:0]   periph_oe,
    input  logic                   sw_out,
    input  logic                   sw_oe,
    input  logic                   in_val,
    output logic                   sel_out,
    output logic                   sel_oe,
    output logic                   func_valid,
    output logic [NUM_FUNCS-2:0]   periph_in,
    output logic                   sw_in
);

    localparam int NUM_PERIPH = NUM_FUNCS - 1;

    logic [NUM_FUNCS-1:0] hit;
    logic [NUM_FUNCS-1:0] src_out;
    logic [NUM_FUNCS-1:0] src_oe;

    assign func_valid = (fsel < FSEL_W'(NUM_FUNCS));

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_slot
        localparam int PIDX = (f < GPIO_FUNC) ? f : f - 1;
        assign hit[f] = (fsel == FSEL_W'(f));
        if (f == GPIO_FUNC) begin : g_sw
            assign src_out[f] = sw_out;
            assign src_oe[f]  = sw_oe;
            assign sw_in      = hit[f] & in_val;
        end else begin : g_hw
            assign src_out[f]      = periph_out[PIDX];
            assign src_oe[f]       = periph_oe[PIDX];
            assign periph_in[PIDX] = hit[f] & in_val;
        end
    end

    assign sel_out = |(hit & src_out);
    assign sel_oe  = |(hit & src_oe);

    // R7: at most one destination ever sees the pad input
    always_comb begin
        a_r7_single_dest: assert ($onehot0({sw_in, periph_in}) || $isunknown({sw_in, periph_in}));
    end

    initial begin
        a_r2_slot_count: assert (NUM_PERIPH >= 1 && GPIO_FUNC < NUM_FUNCS);
    end

endmodule

// File: rtl/pin_pad_path.sv
module pin_pad_path
    import pinmux_pkg::*;
(
    input  pin_ctrl_t  ctrl,
    input  pad_cfg_t   pad_cfg,
    input  logic       func_valid,
    input  logic       sel_out,
    input  logic       sel_oe,
    input  logic       pad_in,
    output logic       in_val,
    output logic       pad_out,
    output logic       pad_oe
);

    logic in_gated;
    logic oe_after_ovr;

    // input buffer off reads as 0 ahead of the override
    assign in_gated     = pad_in & pad_cfg.in_en;
    assign in_val       = ovr_apply(ctrl.in_ovr, in_gated);

    assign pad_out      = ovr_apply(ctrl.out_ovr, sel_out);
    assign oe_after_ovr = ovr_apply(ctrl.oe_ovr, sel_oe);

    // an unowned pin or a disabled output never drives
    assign pad_oe       = oe_after_ovr & func_valid & ~pad_cfg.out_dis;

endmodule

// File: rtl/pinmux_pin.sv
module pinmux_pin
    import pinmux_pkg::*;
#(
    parameter int NUM_FUNCS = 9,
    parameter int GPIO_FUNC = 5,
    parameter int ADDR_W    = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_FUNCS-2:0]  periph_out,
    input  logic [NUM_FUNCS-2:0]  periph_oe,
    output logic [NUM_FUNCS-2:0]  periph_in,
    input  logic                  sw_out,
    input  logic                  sw_oe,
    output logic                  sw_in,
    input  logic                  pad_in,
    output logic                  pad_out,
    output logic                  pad_oe,
    output logic                  pad_slew_fast,
    output logic                  pad_schmitt_en,
    output logic [1:0]            pad_pull,
    output logic [1:0]            pad_drive,
    output logic                  pad_in_en,
    output logic                  pad_out_dis
);

    pin_ctrl_t ctrl_q;
    pad_cfg_t  pad_q;
    logic      func_valid;
    logic      sel_out;
    logic      sel_oe;
    logic      in_val;

    pin_cfg_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .ctrl_q (ctrl_q),
        .pad_q  (pad_q)
    );

    pin_func_mux #(
        .NUM_FUNCS (NUM_FUNCS),
        .GPIO_FUNC (GPIO_FUNC)
    ) u_mux (
        .fsel       (ctrl_q.fsel),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .sw_out     (sw_out),
        .sw_oe      (sw_oe),
        .in_val     (in_val),
        .sel_out    (sel_out),
        .sel_oe     (sel_oe),
        .func_valid (func_valid),
        .periph_in  (periph_in),
        .sw_in      (sw_in)
    );

    pin_pad_path u_path (
        .ctrl       (ctrl_q),
        .pad_cfg    (pad_q),
        .func_valid (func_valid),
        .sel_out    (sel_out),
        .sel_oe     (sel_oe),
        .pad_in     (pad_in),
        .in_val     (in_val),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assign pad_slew_fast  = pad_q.slew_fast;
    assign pad_schmitt_en = pad_q.schmitt;
    assign pad_pull       = pad_q.pull;
    assign pad_drive      = pad_q.drive;
    assign pad_in_en      = pad_q.in_en;
    assign pad_out_dis    = pad_q.out_dis;

    // R9: output disable wins over mux and overrides
    a_r9_outdis_quiet: assert property (@(posedge clk) disable iff (rst)
        pad_out_dis |-> !pad_oe);

    // R4: unowned pin drives nothing and feeds nobody
    a_r4_unowned_silent: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.fsel >= FSEL_W'(NUM_FUNCS)) |-> (!pad_oe && !sw_in && periph_in == '0));

    // R6: enable forced off keeps the pad released
    a_r6_oe_forced_off: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.oe_ovr == OVR_LOW) |-> !pad_oe);

    // R5: forced output levels reach the pad
    a_r5_out_forced: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.out_ovr == OVR_HIGH || ctrl_q.out_ovr == OVR_LOW) |->
            (pad_out == (ctrl_q.out_ovr == OVR_HIGH)));

endmodule

// File: tb/tb_pinmux_pin.sv
module tb_pinmux_pin;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [0:0]  reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  periph_out = '0;
    logic [7:0]  periph_oe = '0;
    logic [7:0]  periph_in;
    logic        sw_out = 1'b0;
    logic        sw_oe = 1'b0;
    logic        sw_in;
    logic        pad_in = 1'b0;
    logic        pad_out;
    logic        pad_oe;
    logic        pad_slew_fast;
    logic        pad_schmitt_en;
    logic [1:0]  pad_pull;
    logic [1:0]  pad_drive;
    logic        pad_in_en;
    logic        pad_out_dis;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pinmux_pin dut (
        .clk            (clk),
        .rst            (rst),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .periph_out     (periph_out),
        .periph_oe      (periph_oe),
        .periph_in      (periph_in),
        .sw_out         (sw_out),
        .sw_oe          (sw_oe),
        .sw_in          (sw_in),
        .pad_in         (pad_in),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe),
        .pad_slew_fast  (pad_slew_fast),
        .pad_schmitt_en (pad_schmitt_en),
        .pad_pull       (pad_pull),
        .pad_drive      (pad_drive),
        .pad_in_en      (pad_in_en),
        .pad_out_dis    (pad_out_dis)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] cword(input int fsel, input int o, input int e, input int i);
        return (32'(i) << 16) | (32'(e) << 14) | (32'(o) << 12) | 32'(fsel);
    endfunction

    function automatic int pidx(input int f);
        return (f < 5) ? f : f - 1;
    endfunction

    function automatic logic ovr(input int mode, input logic v);
        case (mode)
            0: return v;
            1: return ~v;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        pad_in = 1'b1; periph_oe = '1; sw_oe = 1'b1;
        #1;
        rd_chk("R1 ctrl reset", 1'b0, 32'h0000_801F);
        rd_chk("R1 pad reset", 1'b1, 32'h0000_0040);
        chk("R1 pad_oe reset", 32'(pad_oe), 32'd0);
        chk("R1 inputs reset", {23'd0, sw_in, periph_in}, 32'd0);
    endtask

    task automatic t_periph_pass;
        for (int f = 0; f < 9; f++) begin
            if (f == 5) continue;
            wr(1'b0, cword(f, 0, 0, 0));
            for (int p = 0; p < 4; p++) begin
                periph_out = p[0] ? (8'h01 << pidx(f)) : ~(8'h01 << pidx(f));
                periph_oe  = p[1] ? (8'h01 << pidx(f)) : ~(8'h01 << pidx(f));
                sw_out = ~p[0]; sw_oe = ~p[1]; pad_in = 1'b1;
                #1;
                chk($sformatf("R2 out f=%0d p=%0d", f, p), 32'(pad_out), 32'(p[0]));
                chk($sformatf("R2 oe f=%0d p=%0d", f, p), 32'(pad_oe), 32'(p[1]));
                chk($sformatf("R7 route f=%0d", f), {23'd0, sw_in, periph_in}, 32'(8'h01 << pidx(f)));
            end
        end
    endtask

    task automatic t_gpio;
        wr(1'b0, cword(5, 0, 0, 0));
        for (int p = 0; p < 4; p++) begin
            sw_out = p[0]; sw_oe = p[1];
            periph_out = {8{~p[0]}}; periph_oe = {8{~p[1]}};
            pad_in = p[0];
            #1;
            chk($sformatf("R3 out p=%0d", p), 32'(pad_out), 32'(p[0]));
            chk($sformatf("R3 oe p=%0d", p), 32'(pad_oe), 32'(p[1]));
            chk($sformatf("R3 sw_in p=%0d", p), {23'd0, sw_in, periph_in}, {23'd0, p[0], 8'd0});
        end
    endtask

    task automatic t_unowned;
        int codes[3] = '{9, 15, 31};
        foreach (codes[k]) begin
            wr(1'b0, cword(codes[k], 0, 3, 3));
            periph_out = '1; periph_oe = '1; sw_out = 1'b1; sw_oe = 1'b1; pad_in = 1'b1;
            #1;
            chk($sformatf("R4 oe code=%0d", codes[k]), 32'(pad_oe), 32'd0);
            chk($sformatf("R4 inputs code=%0d", codes[k]), {23'd0, sw_in, periph_in}, 32'd0);
        end
    endtask

    task automatic t_out_ovr;
        for (int m = 0; m < 4; m++) begin
            wr(1'b0, cword(0, m, 3, 0));
            for (int v = 0; v < 2; v++) begin
                periph_out = {7'd0, v[0]};
                #1;
                chk($sformatf("R5 mode=%0d v=%0d", m, v), 32'(pad_out), 32'(ovr(m, v[0])));
            end
        end
    endtask

    task automatic t_oe_ovr;
        for (int m = 0; m < 4; m++) begin
            wr(1'b0, cword(7, 0, m, 0));
            for (int v = 0; v < 2; v++) begin
                periph_oe = {1'b0, v[0], 6'd0};
                #1;
                chk($sformatf("R6 mode=%0d v=%0d", m, v), 32'(pad_oe), 32'(ovr(m, v[0])));
            end
        end
    endtask

    task automatic t_in_ovr;
        for (int m = 0; m < 4; m++) begin
            wr(1'b0, cword(2, 0, 0, m));
            for (int v = 0; v < 2; v++) begin
                pad_in = v[0];
                #1;
                chk($sformatf("R7 mode=%0d v=%0d", m, v), {23'd0, sw_in, periph_in},
                    {23'd0, 1'b0, 5'd0, ovr(m, v[0]), 2'd0});
            end
        end
    endtask

    task automatic t_in_en;
        wr(1'b1, 32'h0000_0000);
        wr(1'b0, cword(1, 0, 0, 0));
        pad_in = 1'b1;
        #1;
        chk("R8 gated pass", {24'd0, periph_in}, 32'd0);
        wr(1'b0, cword(1, 0, 0, 1));
        #1;
        chk("R8 gated invert", {24'd0, periph_in}, 32'h0000_0002);
        wr(1'b1, 32'h0000_0040);
        #1;
        chk("R8 enabled invert", {24'd0, periph_in}, 32'd0);
    endtask

    task automatic t_out_dis;
        wr(1'b0, cword(3, 0, 3, 0));
        wr(1'b1, 32'h0000_00C0);
        #1;
        chk("R9 disabled", 32'(pad_oe), 32'd0);
        wr(1'b1, 32'h0000_0040);
        #1;
        chk("R9 released", 32'(pad_oe), 32'd1);
    endtask

    task automatic t_pad_fields;
        wr(1'b1, 32'h0000_0079);
        #1;
        chk("R10 pads A", {26'd0, pad_out_dis, pad_in_en, pad_drive, pad_pull, pad_schmitt_en, pad_slew_fast},
            {26'd0, 1'b0, 1'b1, 2'd3, 2'd2, 1'b0, 1'b1});
        wr(1'b1, 32'h0000_0086);
        #1;
        chk("R10 pads B", {26'd0, pad_out_dis, pad_in_en, pad_drive, pad_pull, pad_schmitt_en, pad_slew_fast},
            {26'd0, 1'b1, 1'b0, 2'd0, 2'd1, 1'b1, 1'b0});
    endtask

    task automatic t_regs;
        wr(1'b0, cword(4, 0, 0, 0));
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 32'hFFFF_FFFF;
        #1;
        chk("R11 before edge", reg_rdata, 32'h0000_0004);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        chk("R11 ctrl mask", reg_rdata, 32'h0003_F01F);
        wr(1'b1, 32'hFFFF_FF00);
        rd_chk("R11 pad mask", 1'b1, 32'h0000_0000);
        rd_chk("R11 ctrl untouched", 1'b0, 32'h0003_F01F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_periph_pass();
        t_gpio();
        t_unowned();
        t_out_ovr();
        t_oe_ovr();
        t_in_ovr();
        t_in_en();
        t_out_dis();
        t_pad_fields();
        t_regs();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule